// File: doc/BRIEF.md
# Static-Address Enumeration Sequencer

This block sits on the controller side of an I3C bus. It hands a dynamic address to one target whose static address is already known, and it needs no firmware action between steps. A single start pulse carries the device-table slot, the static address, the new dynamic address and two option flags. One flag says that the bus characteristics byte (BCR) is already known. The other asks for the device characteristics byte (DCR) and the 48-bit provisioned ID (PID) to be fetched.

The sequencer first primes the chosen device-table entry. It then pushes the address-assignment command (SETDASA) and its payload to a downstream bus engine, and waits for that engine's completion report. When the report is clean it moves the table entry over to the dynamic address. It can then run the directed read commands: GETBCR, GETDCR and GETPID. It pops the returned words, packs them into the entry's second and third words, and finally reports a status code with a one-cycle done pulse.

Bus timing, the physical engine and the broadcast dynamic-address procedure all live outside this block.

Top module: `dasa_enum_seq`

## Requirements
- R1: While `rst` is high, and in the cycle after it, `busy`, `done`, `tbl_we`, `cmd_valid`, `tx_push` and `rx_pop` are all 0.
- R2: The first action is a table write.
  - Address: 0x080 + 16·slot.
  - Byte enables: 4'b1111.
  - Data: bit 9 = 1 (I3C device), bits [7:1] = static address, bit 0 = odd-parity bit. That bit is 1 exactly when the seven address bits hold an even number of ones.
  - All other data bits are 0.
- R3: Next comes a TX push whose `tx_byte` holds the dynamic address in [6:0] with bit 7 = 0. It is followed by a command with `cmd_ccc` = 0x87 and with `cmd_word` fields as follows:
  - bit 30 = 1
  - [23:12] = 1
  - [7:1] = static address
  - bit 0 = 0
  - all other bits 0
- R4: After each command the block waits for `eng_done`.
  - If `eng_nack` or `eng_bad_addr` is high in that cycle, the sequence aborts: no further table write, command or TX push.
  - The status is 1 for NACK and 2 for an invalid address. NACK wins when both are set.
- R5: After a clean SETDASA, the entry's first word is written again at the same address with byte enables 4'b0001. Its low byte is {dynamic address, odd parity of it}.
- R6: When `bcr_known` is 0, a GETBCR command is issued and BCR is taken from `rx_word[7:0]`. The command has `cmd_ccc` = 0x8E, word bit 30 = 1, [23:12] = 1, [7:1] = dynamic address and bit 0 = 1. When `bcr_known` is 1, this step is skipped and `bcr_value` is used instead.
- R7: When `read_ext` is 1, two commands are issued, both with RNW = 1 and addressed to the dynamic address. Both steps are skipped when `read_ext` is 0.
  - GETDCR: `cmd_ccc` 0x8F, length 1. DCR comes from `rx_word[7:0]`.
  - GETPID: `cmd_ccc` 0x8D, length 6. It pops two words: the first is PID[47:16] and the second carries PID[15:0] in bits [15:0].
- R8: Results are written to the table.
  - If `read_ext` is set, the word at address + 4 receives PID[47:16].
  - If BCR was read or `read_ext` is set, the word at address + 8 receives {PID[15:0], BCR, DCR} in bits [31:16], [15:8] and [7:0], all with byte enables 4'b1111. DCR and PID read as 0 when `read_ext` is 0.
- R9: If RX is empty when a read result is due, the sequence aborts with status 3 and `rx_pop` is never raised while `rx_empty` is high.
- R10: Actions occur one per cycle, in this order: R2, R3, R5, R6, R7, R8.
  - `busy` is high from the cycle after an accepted start until the sequence ends.
  - `done` then pulses for one cycle while `busy` is 0, with `status` valid. A clean run gives status 0.
- R11: A `start` while `busy` is high is ignored: the running sequence keeps its slot and addresses, and no second sequence follows.
- R12: A synchronous reset in the middle of a sequence returns the block to idle. No table write follows it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Start pulse, taken only when idle |
| slot_sel | input | 4 | Device-table slot, 0 to 11 |
| static_addr | input | 7 | Target's static address |
| dyn_addr | input | 7 | Dynamic address to assign |
| bcr_known | input | 1 | Skip the BCR read and use `bcr_value` |
| bcr_value | input | 8 | BCR supplied by the host |
| read_ext | input | 1 | Fetch DCR and PID |
| cmd_valid | output | 1 | Command push strobe |
| cmd_ccc | output | 8 | CCC code of the pushed command |
| cmd_word | output | 32 | Command descriptor word |
| tx_push | output | 1 | TX data push strobe |
| tx_byte | output | 8 | TX data byte |
| eng_done | input | 1 | Bus engine completion pulse |
| eng_nack | input | 1 | Completion carries a NACK |
| eng_bad_addr | input | 1 | Completion carries an invalid-address error |
| rx_pop | output | 1 | RX pop strobe |
| rx_word | input | 32 | RX head word |
| rx_empty | input | 1 | RX queue empty |
| tbl_we | output | 1 | Device-table write strobe |
| tbl_addr | output | 12 | Device-table byte address |
| tbl_be | output | 4 | Byte enables |
| tbl_wdata | output | 32 | Device-table write data |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle end-of-sequence pulse |
| status | output | 2 | 0 ok, 1 NACK, 2 invalid address, 3 RX underflow |

## Verification
The assertions assume the following about the bus engine:
- It raises `eng_done` only while a command is outstanding, as a single-cycle pulse.
- `rx_empty` is a true reflection of the queue.
- `slot_sel` is below 12 whenever `start` is taken.

The bench's engine model honours all three. It answers each command exactly once, three cycles after the push, and sets the error flags only together with `eng_done`. It loads RX words at the completion cycle, and removes a word only after the design has popped it. Every slot it drives stays in the 0 to 11 range. Extra start pulses and the mid-sequence reset are injected on their own and never overlap an engine response.

// File: rtl/dasa_enum_pkg.sv
package dasa_enum_pkg;

  localparam logic [7:0] CCC_SETDASA = 8'h87;
  localparam logic [7:0] CCC_GETBCR  = 8'h8E;
  localparam logic [7:0] CCC_GETDCR  = 8'h8F;
  localparam logic [7:0] CCC_GETPID  = 8'h8D;

  typedef enum logic [4:0] {
    S_IDLE, S_RR0, S_TX, S_SET, S_SETW, S_RW,
    S_BCR, S_BCRW, S_BCRP, S_DCR, S_DCRW, S_DCRP,
    S_PID, S_PIDW, S_PID0, S_PID1, S_RR1, S_RR2
  } step_e;

  typedef enum logic [1:0] {ST_OK = 2'd0, ST_NACK = 2'd1, ST_BADDA = 2'd2, ST_UNDER = 2'd3} stat_e;
  typedef enum logic [1:0] {OP_SET, OP_BCR, OP_DCR, OP_PID} op_e;
  typedef enum logic [1:0] {TW_INIT, TW_DYN, TW_PIDHI, TW_CHAR} tw_e;

  // odd parity: the 8-bit address byte always carries an odd number of ones
  function automatic logic odd_par(input logic [6:0] a);
    return ~(^a);
  endfunction

  function automatic logic [7:0] addr_byte(input logic [6:0] a);
    return {a, odd_par(a)};
  endfunction

  function automatic logic [31:0] cmd_fmt(input logic [6:0] a, input logic [11:0] len,
                                          input logic rnw);
    logic [31:0] w;
    w        = '0;
    w[30]    = 1'b1;
    w[23:12] = len;
    w[7:1]   = a;
    w[0]     = rnw;
    return w;
  endfunction

endpackage

// File: rtl/dasa_cmd_build.sv
module dasa_cmd_build
  import dasa_enum_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        cmd_valid,
  input  op_e         op,
  input  logic [6:0]  sa,
  input  logic [6:0]  da,
  output logic [7:0]  ccc,
  output logic [31:0] word
);

  always_comb begin
    unique case (op)
      OP_SET: begin ccc = CCC_SETDASA; word = cmd_fmt(sa, 12'd1, 1'b0); end
      OP_BCR: begin ccc = CCC_GETBCR;  word = cmd_fmt(da, 12'd1, 1'b1); end
      OP_DCR: begin ccc = CCC_GETDCR;  word = cmd_fmt(da, 12'd1, 1'b1); end
      default: begin ccc = CCC_GETPID; word = cmd_fmt(da, 12'd6, 1'b1); end
    endcase
  end

  // R3: the address assignment is a write of one byte to the static address
  assert_setdasa_shape_R3: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && ccc == CCC_SETDASA) |-> (word[0] == 1'b0 && word[23:12] == 12'd1 && word[7:1] == sa));

  // R7: only the ID read moves six bytes
  assert_pid_len_R7: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && word[23:12] == 12'd6) |-> (ccc == CCC_GETPID && word[0]));

endmodule

// File: rtl/dasa_tbl_pack.sv
module dasa_tbl_pack
  import dasa_enum_pkg::*;
#(
  parameter int SLOTS       = 12,
  parameter int TBL_AW      = 12,
  parameter int TBL_BASE    = 'h080,
  parameter int SLOT_STRIDE = 'h10,
  localparam int SLOT_W     = $clog2(SLOTS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  tw_e               sel,
  input  logic [SLOT_W-1:0] slot,
  input  logic [6:0]        sa,
  input  logic [6:0]        da,
  input  logic [7:0]        bcr,
  input  logic [7:0]        dcr,
  input  logic [47:0]       pid,
  output logic [TBL_AW-1:0] addr,
  output logic [3:0]        be,
  output logic [31:0]       wdata
);

  localparam logic [TBL_AW-1:0] BASE = TBL_AW'(TBL_BASE);
  localparam logic [TBL_AW-1:0] STEP = TBL_AW'(SLOT_STRIDE);

  logic [TBL_AW-1:0] slot_base;
  logic [TBL_AW-1:0] word_off;

  assign slot_base = BASE + TBL_AW'(slot) * STEP;

  always_comb begin
    word_off = '0;
    be       = 4'hF;
    wdata    = '0;
    unique case (sel)
      TW_INIT:  wdata = {22'd0, 1'b1, 1'b0, addr_byte(sa)};
      TW_DYN: begin
        be    = 4'b0001;
        wdata = {22'd0, 1'b1, 1'b0, addr_byte(da)};
      end
      TW_PIDHI: begin
        word_off = TBL_AW'(4);
        wdata    = pid[47:16];
      end
      default: begin
        word_off = TBL_AW'(8);
        wdata    = {pid[15:0], bcr, dcr};
      end
    endcase
  end

  assign addr = slot_base + word_off;

  // R2: a full-word entry write carries the device flag and an odd-weight address byte
  assert_rr0_parity_R2: assert property (@(posedge clk) disable iff (rst)
    (we && sel == TW_INIT) |-> (wdata[9] && (^wdata[7:0]) && be == 4'hF));

  // R5: the dynamic-address update touches only the low byte lane
  assert_dyn_lane_R5: assert property (@(posedge clk) disable iff (rst)
    (we && sel == TW_DYN) |-> (be == 4'b0001 && (^wdata[7:0])));

endmodule

// File: rtl/dasa_enum_fsm.sv
module dasa_enum_fsm
  import dasa_enum_pkg::*;
#(
  parameter int SLOTS   = 12,
  localparam int SLOT_W = $clog2(SLOTS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [SLOT_W-1:0] slot_sel,
  input  logic [6:0]        static_addr,
  input  logic [6:0]        dyn_addr,
  input  logic              bcr_known,
  input  logic [7:0]        bcr_value,
  input  logic              read_ext,
  input  logic              eng_done,
  input  logic              eng_nack,
  input  logic              eng_bad_addr,
  input  logic [31:0]       rx_word,
  input  logic              rx_empty,
  output logic              cmd_valid,
  output op_e               cmd_op,
  output logic              tx_push,
  output logic              rx_pop,
  output logic              tbl_we,
  output tw_e               tbl_sel,
  output logic [SLOT_W-1:0] slot_q,
  output logic [6:0]        sa_q,
  output logic [6:0]        da_q,
  output logic [7:0]        bcr_q,
  output logic [7:0]        dcr_q,
  output logic [47:0]       pid_q,
  output logic              busy,
  output logic              done,
  output stat_e             status
);

  step_e st, nxt;
  logic  bk_q, ext_q;
  logic  fin;
  stat_e fin_code;

  // named events for the checks below
  logic  accept_w, resp_bad_w, wait_st_w, pop_st_w;
  stat_e resp_code_w;

  assign accept_w    = (st == S_IDLE) && start;
  assign resp_bad_w  = eng_nack | eng_bad_addr;
  assign resp_code_w = eng_nack ? ST_NACK : ST_BADDA;
  assign wait_st_w   = (st == S_SETW) || (st == S_BCRW) || (st == S_DCRW) || (st == S_PIDW);
  assign pop_st_w    = (st == S_BCRP) || (st == S_DCRP) || (st == S_PID0) || (st == S_PID1);

  always_comb begin
    nxt      = st;
    fin      = 1'b0;
    fin_code = ST_OK;
    unique case (st)
      S_IDLE: if (start) nxt = S_RR0;
      S_RR0:  nxt = S_TX;
      S_TX:   nxt = S_SET;
      S_SET:  nxt = S_SETW;
      S_SETW: if (eng_done) begin
        if (resp_bad_w) begin fin = 1'b1; fin_code = resp_code_w; end
        else nxt = S_RW;
      end
      S_RW: begin
        if (!bk_q)      nxt = S_BCR;
        else if (ext_q) nxt = S_DCR;
        else            fin = 1'b1;
      end
      S_BCR:  nxt = S_BCRW;
      S_BCRW: if (eng_done) begin
        if (resp_bad_w) begin fin = 1'b1; fin_code = resp_code_w; end
        else nxt = S_BCRP;
      end
      S_BCRP: begin
        if (rx_empty) begin fin = 1'b1; fin_code = ST_UNDER; end
        else nxt = ext_q ? S_DCR : S_RR2;
      end
      S_DCR:  nxt = S_DCRW;
      S_DCRW: if (eng_done) begin
        if (resp_bad_w) begin fin = 1'b1; fin_code = resp_code_w; end
        else nxt = S_DCRP;
      end
      S_DCRP: begin
        if (rx_empty) begin fin = 1'b1; fin_code = ST_UNDER; end
        else nxt = S_PID;
      end
      S_PID:  nxt = S_PIDW;
      S_PIDW: if (eng_done) begin
        if (resp_bad_w) begin fin = 1'b1; fin_code = resp_code_w; end
        else nxt = S_PID0;
      end
      S_PID0: begin
        if (rx_empty) begin fin = 1'b1; fin_code = ST_UNDER; end
        else nxt = S_PID1;
      end
      S_PID1: begin
        if (rx_empty) begin fin = 1'b1; fin_code = ST_UNDER; end
        else nxt = S_RR1;
      end
      S_RR1:  nxt = S_RR2;
      S_RR2:  fin = 1'b1;
      default: nxt = S_IDLE;
    endcase
    if (fin) nxt = S_IDLE;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st     <= S_IDLE;
      done   <= 1'b0;
      status <= ST_OK;
    end else begin
      st   <= nxt;
      done <= fin;
      if (fin) status <= fin_code;
    end
  end

  always_ff @(posedge clk) begin
    if (accept_w) begin
      slot_q <= slot_sel;
      sa_q   <= static_addr;
      da_q   <= dyn_addr;
      bk_q   <= bcr_known;
      ext_q  <= read_ext;
      bcr_q  <= bcr_value;
      dcr_q  <= '0;
      pid_q  <= '0;
    end
    if (rx_pop) begin
      unique case (st)
        S_BCRP:  bcr_q <= rx_word[7:0];
        S_DCRP:  dcr_q <= rx_word[7:0];
        S_PID0:  pid_q[47:16] <= rx_word;
        default: pid_q[15:0] <= rx_word[15:0];
      endcase
    end
  end

  always_comb begin
    busy      = (st != S_IDLE);
    tx_push   = (st == S_TX);
    rx_pop    = pop_st_w && !rx_empty;
    cmd_valid = (st == S_SET) || (st == S_BCR) || (st == S_DCR) || (st == S_PID);
    tbl_we    = (st == S_RR0) || (st == S_RW) || (st == S_RR1) || (st == S_RR2);
    unique case (st)
      S_BCR:   cmd_op = OP_BCR;
      S_DCR:   cmd_op = OP_DCR;
      S_PID:   cmd_op = OP_PID;
      default: cmd_op = OP_SET;
    endcase
    unique case (st)
      S_RW:    tbl_sel = TW_DYN;
      S_RR1:   tbl_sel = TW_PIDHI;
      S_RR2:   tbl_sel = TW_CHAR;
      default: tbl_sel = TW_INIT;
    endcase
  end

  assert_one_action_R10: assert property (@(posedge clk) disable iff (rst)
    $onehot0({tbl_we, cmd_valid, tx_push, rx_pop}));

  assert_done_idle_R10: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);

  assert_pop_safe_R9: assert property (@(posedge clk) disable iff (rst)
    rx_pop |-> !rx_empty);

  assert_nack_abort_R4: assert property (@(posedge clk) disable iff (rst)
    (wait_st_w && eng_done && eng_nack) |=> (done && status == ST_NACK && !busy));

  assert_underflow_abort_R9: assert property (@(posedge clk) disable iff (rst)
    (pop_st_w && rx_empty) |=> (done && status == ST_UNDER));

  assert_slot_hold_R11: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy)) |-> ($stable(slot_q) && $stable(da_q)));

  assert_reset_idle_R12: assert property (@(posedge clk)
    rst |=> (!busy && !tbl_we && !done));

endmodule

// File: rtl/dasa_enum_seq.sv
module dasa_enum_seq
  import dasa_enum_pkg::*;
#(
  parameter int SLOTS       = 12,
  parameter int TBL_AW      = 12,
  parameter int TBL_BASE    = 'h080,
  parameter int SLOT_STRIDE = 'h10,
  localparam int SLOT_W     = $clog2(SLOTS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [SLOT_W-1:0] slot_sel,
  input  logic [6:0]        static_addr,
  input  logic [6:0]        dyn_addr,
  input  logic              bcr_known,
  input  logic [7:0]        bcr_value,
  input  logic              read_ext,
  output logic              cmd_valid,
  output logic [7:0]        cmd_ccc,
  output logic [31:0]       cmd_word,
  output logic              tx_push,
  output logic [7:0]        tx_byte,
  input  logic              eng_done,
  input  logic              eng_nack,
  input  logic              eng_bad_addr,
  output logic              rx_pop,
  input  logic [31:0]       rx_word,
  input  logic              rx_empty,
  output logic              tbl_we,
  output logic [TBL_AW-1:0] tbl_addr,
  output logic [3:0]        tbl_be,
  output logic [31:0]       tbl_wdata,
  output logic              busy,
  output logic              done,
  output logic [1:0]        status
);

  op_e               op_w;
  tw_e               tsel_w;
  stat_e             stat_w;
  logic [SLOT_W-1:0] slot_w;
  logic [6:0]        sa_w, da_w;
  logic [7:0]        bcr_w, dcr_w;
  logic [47:0]       pid_w;

  dasa_enum_fsm #(.SLOTS(SLOTS)) u_fsm (
    .clk(clk), .rst(rst), .start(start), .slot_sel(slot_sel),
    .static_addr(static_addr), .dyn_addr(dyn_addr), .bcr_known(bcr_known),
    .bcr_value(bcr_value), .read_ext(read_ext), .eng_done(eng_done),
    .eng_nack(eng_nack), .eng_bad_addr(eng_bad_addr), .rx_word(rx_word),
    .rx_empty(rx_empty), .cmd_valid(cmd_valid), .cmd_op(op_w), .tx_push(tx_push),
    .rx_pop(rx_pop), .tbl_we(tbl_we), .tbl_sel(tsel_w), .slot_q(slot_w),
    .sa_q(sa_w), .da_q(da_w), .bcr_q(bcr_w), .dcr_q(dcr_w), .pid_q(pid_w),
    .busy(busy), .done(done), .status(stat_w)
  );

  dasa_cmd_build u_cmd (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .op(op_w), .sa(sa_w), .da(da_w),
    .ccc(cmd_ccc), .word(cmd_word)
  );

  dasa_tbl_pack #(
    .SLOTS(SLOTS), .TBL_AW(TBL_AW), .TBL_BASE(TBL_BASE), .SLOT_STRIDE(SLOT_STRIDE)
  ) u_tbl (
    .clk(clk), .rst(rst), .we(tbl_we), .sel(tsel_w), .slot(slot_w), .sa(sa_w),
    .da(da_w), .bcr(bcr_w), .dcr(dcr_w), .pid(pid_w),
    .addr(tbl_addr), .be(tbl_be), .wdata(tbl_wdata)
  );

  assign tx_byte = {1'b0, da_w};
  assign status  = stat_w;

endmodule

// File: tb/dasa_enum_seq_test.sv
module dasa_enum_seq_test;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [3:0]  slot_sel = '0;
  logic [6:0]  static_addr = '0, dyn_addr = '0;
  logic        bcr_known = 1'b0, read_ext = 1'b0;
  logic [7:0]  bcr_value = '0;
  logic        eng_done = 1'b0, eng_nack = 1'b0, eng_bad_addr = 1'b0;
  logic [31:0] rx_word = '0;
  logic        rx_empty = 1'b1;
  logic        cmd_valid, tx_push, rx_pop, tbl_we, busy, done;
  logic [7:0]  cmd_ccc, tx_byte;
  logic [31:0] cmd_word, tbl_wdata;
  logic [11:0] tbl_addr;
  logic [3:0]  tbl_be;
  logic [1:0]  status;

  always #5 clk = ~clk;

  dasa_enum_seq uut (
    .clk(clk), .rst(rst), .start(start), .slot_sel(slot_sel), .static_addr(static_addr),
    .dyn_addr(dyn_addr), .bcr_known(bcr_known), .bcr_value(bcr_value), .read_ext(read_ext),
    .cmd_valid(cmd_valid), .cmd_ccc(cmd_ccc), .cmd_word(cmd_word), .tx_push(tx_push),
    .tx_byte(tx_byte), .eng_done(eng_done), .eng_nack(eng_nack), .eng_bad_addr(eng_bad_addr),
    .rx_pop(rx_pop), .rx_word(rx_word), .rx_empty(rx_empty), .tbl_we(tbl_we),
    .tbl_addr(tbl_addr), .tbl_be(tbl_be), .tbl_wdata(tbl_wdata), .busy(busy),
    .done(done), .status(status)
  );

  int vectors = 0, miscompares = 0;

  // device answers held by the engine model
  localparam logic [7:0]  DEV_BCR = 8'h26;
  localparam logic [7:0]  DEV_DCR = 8'hC4;
  localparam logic [47:0] DEV_PID = 48'h1234_5678_9ABC;

  logic [51:0] exp_q[$];
  string       tag_q[$];
  logic [31:0] rxq[$];
  int          fail_idx = 0, fail_kind = 0, pid_words = 2, cmd_n = 0;
  int          done_seen = 0;
  logic [1:0]  exp_status = 2'd0;

  task automatic check(input string req, input logic ok, input logic [63:0] act, input logic [63:0] exp);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic par7(input logic [6:0] a);
    return ($countones(a) % 2) == 0;
  endfunction

  function automatic logic [51:0] ev_tbl(input logic [11:0] a, input logic [3:0] be, input logic [31:0] d);
    return {4'd1, a, be, d};
  endfunction

  function automatic logic [51:0] ev_cmd(input logic [7:0] ccc, input logic [6:0] ad, input int len, input logic rnw);
    logic [31:0] w;
    w = (32'd1 << 30) | (32'(len) << 12) | (32'(ad) << 1) | 32'(rnw);
    return {4'd2, 4'd0, ccc, 4'd0, w};
  endfunction

  // bus engine model: answers each command three cycles after the push
  initial begin
    int  cnt = 0;
    bit  pop_pend = 0;
    logic [7:0] cur = '0;
    forever begin
      @(negedge clk);
      if (rst) begin cnt = 0; pop_pend = 0; rxq.delete(); end
      if (pop_pend && rxq.size() > 0) void'(rxq.pop_front());
      pop_pend = 0;
      eng_done = 0; eng_nack = 0; eng_bad_addr = 0;
      if (cnt > 0) begin
        cnt--;
        if (cnt == 0) begin
          eng_done = 1;
          if (cmd_n == fail_idx) begin
            eng_nack     = (fail_kind & 1) != 0;
            eng_bad_addr = (fail_kind & 2) != 0;
          end else if (cur == 8'h8E) rxq.push_back({24'h5A5A5A, DEV_BCR});
          else if (cur == 8'h8F) rxq.push_back({24'hA5A5A5, DEV_DCR});
          else if (cur == 8'h8D) begin
            rxq.push_back(DEV_PID[47:16]);
            if (pid_words > 1) rxq.push_back({16'h7E7E, DEV_PID[15:0]});
          end
        end
      end
      rx_empty = (rxq.size() == 0);
      rx_word  = rx_empty ? 32'd0 : rxq[0];
      #1;
      pop_pend = rx_pop;
      if (cmd_valid && !rst) begin cnt = 3; cur = cmd_ccc; cmd_n++; end
    end
  end

  // per-clock comparison of every outward action against the expected stream
  initial begin
    forever begin
      logic [51:0] got;
      bit          any;
      @(negedge clk);
      #2;
      any = 1'b1;
      if (tbl_we)         got = {4'd1, tbl_addr, tbl_be, tbl_wdata};
      else if (cmd_valid) got = {4'd2, 4'd0, cmd_ccc, 4'd0, cmd_word};
      else if (tx_push)   got = {4'd3, 12'd0, 4'd0, 24'd0, tx_byte};
      else any = 1'b0;
      if (any) begin
        check("R10 busy during action", busy, 64'(busy), 64'd1);
        if (exp_q.size() == 0) check("R4/R11/R12 unexpected action", 1'b0, 64'(got), 64'd0);
        else begin
          logic [51:0] e;
          string       t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          check(t, got == e, 64'(got), 64'(e));
        end
      end
      if (done) begin
        done_seen++;
        check("R10 done while idle", !busy, 64'(busy), 64'd0);
        check("R4/R9/R10 status", status == exp_status, 64'(status), 64'(exp_status));
      end
    end
  end

  task automatic push_e(input logic [51:0] e, input string t);
    exp_q.push_back(e);
    tag_q.push_back(t);
  endtask

  task automatic run(input int slot, input logic [6:0] sa, input logic [6:0] da, input bit bk,
                     input logic [7:0] bv, input bit ext, input int fidx, input int fkind,
                     input int pidw, input bit mid, input logic [1:0] est);
    logic [11:0] base;
    bit          stop;
    int          n;
    int          d0;
    logic [7:0]  bcr_e;
    base = 12'h080 + 12'(slot * 16);
    stop = 0;
    n = 1;
    push_e(ev_tbl(base, 4'hF, {22'd0, 1'b1, 1'b0, sa, par7(sa)}), "R2 entry prime");
    push_e({4'd3, 12'd0, 4'd0, 24'd0, 1'b0, da}, "R3 tx dynamic address");
    push_e(ev_cmd(8'h87, sa, 1, 1'b0), "R3 setdasa command");
    if (fidx == 1) stop = 1;
    if (!stop) push_e(ev_tbl(base, 4'b0001, {22'd0, 1'b1, 1'b0, da, par7(da)}), "R5 dynamic rewrite");
    if (!stop && !bk) begin
      push_e(ev_cmd(8'h8E, da, 1, 1'b1), "R6 getbcr command");
      n++;
      if (fidx == n) stop = 1;
    end
    if (!stop && ext) begin
      push_e(ev_cmd(8'h8F, da, 1, 1'b1), "R7 getdcr command");
      n++;
      if (fidx == n) stop = 1;
      if (!stop) begin
        push_e(ev_cmd(8'h8D, da, 6, 1'b1), "R7 getpid command");
        n++;
        if (fidx == n) stop = 1;
      end
      if (!stop && pidw < 2) stop = 1;
    end
    bcr_e = bk ? bv : DEV_BCR;
    if (!stop && ext) push_e(ev_tbl(base + 12'd4, 4'hF, DEV_PID[47:16]), "R8 pid high word");
    if (!stop && (!bk || ext))
      push_e(ev_tbl(base + 12'd8, 4'hF, ext ? {DEV_PID[15:0], bcr_e, DEV_DCR} : {16'd0, bcr_e, 8'd0}),
             "R8 characteristics word");
    fail_idx = fidx; fail_kind = fkind; pid_words = pidw; cmd_n = 0; exp_status = est;
    d0 = done_seen;
    slot_sel = 4'(slot); static_addr = sa; dyn_addr = da; bcr_known = bk; bcr_value = bv; read_ext = ext;
    start = 1;
    @(negedge clk);
    start = 0;
    if (mid) begin
      repeat (4) @(negedge clk);
      slot_sel = 4'(11 - slot); dyn_addr = ~da; start = 1;
      @(negedge clk);
      start = 0;
    end
    for (int i = 0; i < 300 && done_seen == d0; i++) @(negedge clk);
    check("R10 sequence finished", done_seen == d0 + 1, 64'(done_seen - d0), 64'd1);
    repeat (8) @(negedge clk);
    check("R11 single run, idle after", done_seen == d0 + 1 && !busy, 64'(busy), 64'd0);
    check("R10 all actions seen", exp_q.size() == 0, 64'(exp_q.size()), 64'd0);
    exp_q.delete(); tag_q.delete();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset quiet", !busy && !done && !tbl_we && !cmd_valid && !tx_push && !rx_pop,
          64'({busy, done, tbl_we, cmd_valid, tx_push, rx_pop}), 64'd0);
    rst = 0;
    @(negedge clk);
    check("R1 idle after reset", !busy && !done, 64'({busy, done}), 64'd0);
    // full sequence, all reads
    run(3, 7'h50, 7'h0A, 0, 8'h00, 1, 0, 0, 2, 0, 2'd0);
    // BCR known, nothing fetched
    run(0, 7'h3B, 7'h11, 1, 8'h99, 0, 0, 0, 2, 0, 2'd0);
    // BCR known, extended fetch, top slot
    run(11, 7'h7F, 7'h00, 1, 8'h5C, 1, 0, 0, 2, 0, 2'd0);
    // BCR read only
    run(5, 7'h01, 7'h7E, 0, 8'h00, 0, 0, 0, 2, 0, 2'd0);
    // R4: NACK on address assignment
    run(2, 7'h22, 7'h33, 0, 8'h00, 1, 1, 1, 2, 0, 2'd1);
    // R4: invalid address on DCR read
    run(7, 7'h44, 7'h55, 0, 8'h00, 1, 3, 2, 2, 0, 2'd2);
    // R4: both flags, NACK wins, on BCR read
    run(8, 7'h12, 7'h34, 0, 8'h00, 0, 2, 3, 2, 0, 2'd1);
    // R9: second PID word missing
    run(9, 7'h66, 7'h77, 1, 8'h10, 1, 0, 0, 1, 0, 2'd3);
    // R11: start during busy is ignored
    run(4, 7'h2A, 7'h15, 0, 8'h00, 1, 0, 0, 2, 1, 2'd0);
    // R12: reset in the middle of a sequence
    begin
      int d0;
      logic [11:0] base;
      base = 12'h080 + 12'd16;
      push_e(ev_tbl(base, 4'hF, {22'd0, 1'b1, 1'b0, 7'h09, par7(7'h09)}), "R12 prime before reset");
      push_e({4'd3, 12'd0, 4'd0, 24'd0, 8'h0C}, "R12 tx before reset");
      d0 = done_seen;
      slot_sel = 4'd1; static_addr = 7'h09; dyn_addr = 7'h0C; bcr_known = 0; read_ext = 1;
      start = 1;
      @(negedge clk);
      start = 0;
      @(negedge clk);
      rst = 1;
      @(negedge clk);
      rst = 0;
      check("R12 idle after mid reset", !busy, 64'(busy), 64'd0);
      repeat (20) @(negedge clk);
      check("R12 no further actions", exp_q.size() == 0 && !busy && done_seen == d0,
            64'(exp_q.size()), 64'd0);
    end
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

endmodule